// File: doc/BRIEF.md
# Cyclic Snapshot Buffer with Pattern Injection

This block holds the recent history of one digitizer channel in a circular memory. In record mode every 10-bit sample that arrives on the trigger clock is written at a rising pointer that wraps at the buffer depth, and the live sample also goes on to the processing logic one cycle later. When a stop command arrives, the block keeps writing for a programmable number of post-stop samples. It then halts and latches the address of the last sample it wrote. The frozen history can then be read by a host port in age order: logical address 0 is the oldest sample and logical address DEPTH-1 is the newest.

In source mode the same memory becomes a pattern generator. The host loads the memory at physical addresses. The block then replays the memory into the processing path in place of live data, starting at physical address 0 and wrapping forever until the mode changes. This allows recorded or simulated events to be pushed through the downstream algorithms. A start command clears the frozen condition and restarts circular writing from physical address 0.

With the default parameters the memory holds 500 samples, which is 5 us at 100 MHz. A post-stop length of 100 samples gives about 1 us of extra recording after the stop.

Top module: `csb_snapshot_top`

## Requirements
- R1: While reset is applied and right after it, `proc_o` reads 0, `frozen_o` reads 0 and `host_rvalid_o` reads 0.
- R2: With `mode_src_i` = 0, `proc_o` equals the value that `live_i` had one clock earlier.
- R3: With `post_len_i` = N > 0, a stop in record mode causes the stop-cycle sample and then exactly N more samples to be written. `frozen_o` is low after the N-1-th extra write and high after the N-th.
- R4: A host read with `host_rd_i` = 1 returns data on `host_rdata_o` one clock later, with `host_rvalid_o` high for exactly that one cycle.
- R5: In record mode while frozen, logical address a (0 to DEPTH-1) reads the a-th oldest of the last DEPTH written samples. Live samples arriving after the freeze are not stored.
- R6: A `start_i` pulse clears `frozen_o` on the next clock and restarts writing at physical address 0, so a later capture holds only new samples.
- R7: With `mode_src_i` = 1, `proc_o` presents memory address k mod DEPTH on the k-th clock after the mode went high (k = 0, 1, ...). It wraps continuously.
- R8: With `mode_src_i` = 1, host writes and reads use physical addresses, and a written value reads back unchanged.
- R9: A stop command is ignored while `mode_src_i` = 1: `frozen_o` stays low and recording resumes when the mode returns to 0.
- R10: With `post_len_i` = 0, the freeze happens on the stop cycle itself, and the stop-cycle sample is the newest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trigger-rate sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| live_i | input | 10 | Live digitizer sample |
| mode_src_i | input | 1 | 0 = record/dump, 1 = replay memory as source |
| start_i | input | 1 | Clear freeze and restart writing at address 0 |
| stop_i | input | 1 | Begin post-stop countdown (record mode only) |
| post_len_i | input | 16 | Number of samples written after the stop |
| frozen_o | output | 1 | History frozen, ready for readout |
| proc_o | output | 10 | Sample toward the processing logic |
| host_addr_i | input | 9 | Host address: logical in record mode, physical in source mode |
| host_rd_i | input | 1 | Host read request |
| host_wr_i | input | 1 | Host write request (dropped while recording writes) |
| host_wdata_i | input | 10 | Host write data |
| host_rdata_o | output | 10 | Host read data |
| host_rvalid_o | output | 1 | Host read data valid |

## Verification
The assertions assume that `host_addr_i` stays below DEPTH and that `live_i` and the control inputs are driven to known levels from time zero. They also assume that `post_len_i` is held steady while a post-stop countdown runs. The stimulus drives every input from the first cycle and uses only addresses inside the memory. It changes `post_len_i` only before a start pulse. It issues host writes only in source mode, where the recording port is idle.

// File: rtl/csb_pkg.sv
package csb_pkg;
  typedef enum logic [1:0] {
    WR_RUN  = 2'd0,
    WR_POST = 2'd1,
    WR_HOLD = 2'd2
  } wr_state_t;
endpackage

// File: rtl/csb_mem.sv
module csb_mem #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 500,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [AW-1:0]     rb_addr,
  output logic [DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] store [DEPTH];

  // storage carries no reset; contents are defined by writes only
  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  assign ra_data = store[ra_addr];
  assign rb_data = store[rb_addr];
endmodule

// File: rtl/csb_wr_ctrl.sv
module csb_wr_ctrl
  import csb_pkg::*;
#(
  parameter int DEPTH = 500,
  parameter int AW    = $clog2(DEPTH),
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_mode,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] post_len,
  output logic             rec_we,
  output logic [AW-1:0]    wptr,
  output logic [AW-1:0]    last_ptr,
  output logic             frozen
);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  wr_state_t        st_q, st_d;
  logic [AW-1:0]    wptr_q, wptr_d;
  logic [AW-1:0]    last_q, last_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             adv;
  logic [AW-1:0]    wptr_inc;

  assign wptr_inc = (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
  assign adv      = start | rec_mode;

  always_comb begin
    st_d   = st_q;
    wptr_d = wptr_q;
    last_d = last_q;
    cnt_d  = cnt_q;
    rec_we = 1'b0;
    if (start) begin
      st_d   = WR_RUN;
      wptr_d = '0;
    end else if (rec_mode) begin
      case (st_q)
        WR_RUN: begin
          rec_we = 1'b1;
          wptr_d = wptr_inc;
          if (stop) begin
            if (post_len == '0) begin
              st_d   = WR_HOLD;
              last_d = wptr_q;
            end else begin
              st_d  = WR_POST;
              cnt_d = post_len;
            end
          end
        end
        WR_POST: begin
          rec_we = 1'b1;
          wptr_d = wptr_inc;
          cnt_d  = cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            st_d   = WR_HOLD;
            last_d = wptr_q;
          end
        end
        WR_HOLD: begin
          st_d = WR_HOLD;
        end
        default: st_d = WR_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WR_RUN;
      wptr_q <= '0;
      last_q <= '0;
      cnt_q  <= '0;
    end else if (adv) begin
      st_q   <= st_d;
      wptr_q <= wptr_d;
      last_q <= last_d;
      cnt_q  <= cnt_d;
    end
  end

  assign wptr     = wptr_q;
  assign last_ptr = last_q;
  assign frozen   = (st_q == WR_HOLD);
endmodule

// File: rtl/csb_replay.sv
module csb_replay #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 500,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_mode,
  input  logic [DATA_W-1:0] live,
  input  logic [DATA_W-1:0] mem_q,
  output logic [AW-1:0]     rptr,
  output logic [DATA_W-1:0] proc
);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [AW-1:0]     rptr_q, rptr_d;
  logic [DATA_W-1:0] proc_q, proc_d;

  always_comb begin
    if (src_mode) begin
      rptr_d = (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;
      proc_d = mem_q;
    end else begin
      rptr_d = '0;
      proc_d = live;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      proc_q <= '0;
    end else begin
      rptr_q <= rptr_d;
      proc_q <= proc_d;
    end
  end

  assign rptr = rptr_q;
  assign proc = proc_q;
endmodule

// File: rtl/csb_host_port.sv
module csb_host_port #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 500,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_mode,
  input  logic [AW-1:0]     last_ptr,
  input  logic              rec_we,
  input  logic [AW-1:0]     addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] mem_q,
  output logic [AW-1:0]     phys,
  output logic              host_we,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam logic [AW-1:0] PTR_LAST  = AW'(DEPTH - 1);
  localparam logic [AW:0]   DEPTH_EXT = (AW+1)'(DEPTH);

  logic [AW-1:0]     oldest, base;
  logic [AW:0]       sum;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q;

  assign oldest  = (last_ptr == PTR_LAST) ? '0 : last_ptr + 1'b1;
  assign base    = src_mode ? '0 : oldest;
  assign sum     = {1'b0, base} + {1'b0, addr};
  assign phys    = (sum >= DEPTH_EXT) ? AW'(sum - DEPTH_EXT) : sum[AW-1:0];
  assign host_we = wr & ~rec_we;
  assign rdata_d = rd ? mem_q : rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rd;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
endmodule

// File: rtl/csb_snapshot_top.sv
module csb_snapshot_top #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 500,
  parameter int CNT_W  = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] live_i,
  input  logic              mode_src_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [CNT_W-1:0]  post_len_i,
  output logic              frozen_o,
  output logic [DATA_W-1:0] proc_o,
  input  logic [AW-1:0]     host_addr_i,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_rvalid_o
);
  logic [1:0]        rst_sync;
  logic              rst_n_s;
  logic              rec_we, host_we, mem_we;
  logic [AW-1:0]     wptr, last_ptr, rptr, host_phys, mem_waddr;
  logic [DATA_W-1:0] mem_wdata, replay_q, host_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  csb_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst_n(rst_n_s), .rec_mode(~mode_src_i), .start(start_i),
    .stop(stop_i), .post_len(post_len_i), .rec_we(rec_we), .wptr(wptr),
    .last_ptr(last_ptr), .frozen(frozen_o)
  );

  csb_replay #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_replay (
    .clk(clk), .rst_n(rst_n_s), .src_mode(mode_src_i), .live(live_i),
    .mem_q(replay_q), .rptr(rptr), .proc(proc_o)
  );

  csb_host_port #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_host (
    .clk(clk), .rst_n(rst_n_s), .src_mode(mode_src_i), .last_ptr(last_ptr),
    .rec_we(rec_we), .addr(host_addr_i), .rd(host_rd_i), .wr(host_wr_i),
    .mem_q(host_q), .phys(host_phys), .host_we(host_we),
    .rdata(host_rdata_o), .rvalid(host_rvalid_o)
  );

  assign mem_we    = rec_we | host_we;
  assign mem_waddr = rec_we ? wptr : host_phys;
  assign mem_wdata = rec_we ? live_i : host_wdata_i;

  csb_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .ra_addr(rptr), .ra_data(replay_q),
    .rb_addr(host_phys), .rb_data(host_q)
  );
endmodule

// File: rtl/csb_snapshot_chk.sv
module csb_snapshot_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic [DATA_W-1:0] live_i,
  input logic              mode_src_i,
  input logic              start_i,
  input logic              frozen_o,
  input logic [DATA_W-1:0] proc_o,
  input logic              host_rd_i,
  input logic              host_rvalid_o,
  input logic              rec_we
);
  AST_PASS_LIVE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !mode_src_i |=> proc_o == $past(live_i)); // R2
  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n_s)
    host_rd_i |=> host_rvalid_o); // R4
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !host_rd_i |=> !host_rvalid_o); // R4
  AST_NO_WRITE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n_s)
    frozen_o |-> !rec_we); // R5
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n_s)
    frozen_o && !start_i |=> frozen_o); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_s)
    start_i |=> !frozen_o); // R6
  AST_SRC_NO_FREEZE: assert property (@(posedge clk) disable iff (!rst_n_s)
    mode_src_i && !frozen_o |=> !frozen_o); // R9
endmodule

bind csb_snapshot_top csb_snapshot_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .live_i(live_i), .mode_src_i(mode_src_i),
  .start_i(start_i), .frozen_o(frozen_o), .proc_o(proc_o),
  .host_rd_i(host_rd_i), .host_rvalid_o(host_rvalid_o), .rec_we(rec_we)
);

// File: tb/test_csb_snapshot_top.sv
module test_csb_snapshot_top;
  localparam int DATA_W = 10;
  localparam int DEPTH  = 500;
  localparam int CNT_W  = 16;
  localparam int AW     = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n;
  logic [DATA_W-1:0] live_i;
  logic              mode_src_i, start_i, stop_i;
  logic [CNT_W-1:0]  post_len_i;
  logic              frozen_o;
  logic [DATA_W-1:0] proc_o;
  logic [AW-1:0]     host_addr_i;
  logic              host_rd_i, host_wr_i;
  logic [DATA_W-1:0] host_wdata_i, host_rdata_o;
  logic              host_rvalid_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  csb_snapshot_top #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_csb_snapshot_top (
    .clk(clk), .rst_n(rst_n), .live_i(live_i), .mode_src_i(mode_src_i),
    .start_i(start_i), .stop_i(stop_i), .post_len_i(post_len_i),
    .frozen_o(frozen_o), .proc_o(proc_o), .host_addr_i(host_addr_i),
    .host_rd_i(host_rd_i), .host_wr_i(host_wr_i), .host_wdata_i(host_wdata_i),
    .host_rdata_o(host_rdata_o), .host_rvalid_o(host_rvalid_o)
  );

  function automatic logic [DATA_W-1:0] sval(int j, int seed);
    return DATA_W'((j * 7 + seed) & 10'h3FF);
  endfunction
  function automatic logic [DATA_W-1:0] pval(int a);
    return DATA_W'((a * 13 + 5) & 10'h3FF);
  endfunction

  task automatic check(string req, int actual, int expected);
    n_chk++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic host_read(int a, output int d, output int v);
    @(negedge clk);
    host_addr_i = AW'(a);
    host_rd_i   = 1'b1;
    @(negedge clk);
    host_rd_i = 1'b0;
    d = int'(host_rdata_o);
    v = int'(host_rvalid_o);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 proc_o in reset", int'(proc_o), 0);
    check("R1 frozen_o in reset", int'(frozen_o), 0);
    check("R1 rvalid in reset", int'(host_rvalid_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 frozen_o after reset", int'(frozen_o), 0);
    check("R1 rvalid after reset", int'(host_rvalid_o), 0);
  endtask

  task automatic t_passthrough();
    for (int k = 0; k < 8; k++) begin
      live_i = sval(k, 100);
      @(negedge clk);
      check("R2 live to proc_o", int'(proc_o), int'(sval(k, 100)));
    end
  endtask

  task automatic t_capture(int s, int n, int seed, string req);
    int d, v, last;
    post_len_i = CNT_W'(n);
    start_i    = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R6 start clears frozen", int'(frozen_o), 0);
    for (int j = 0; j <= s + n; j++) begin
      if (j == s + n) check({req, " not frozen before last write"}, int'(frozen_o), 0);
      live_i = sval(j, seed);
      stop_i = (j == s);
      @(negedge clk);
    end
    stop_i = 1'b0;
    check({req, " frozen after last write"}, int'(frozen_o), 1);
    for (int j = 0; j < 20; j++) begin
      live_i = 10'h155;
      @(negedge clk);
    end
    last = s + n;
    host_read(0, d, v);
    check("R4 rvalid on read", v, 1);
    check("R5 oldest entry", d, int'(sval(last - (DEPTH - 1), seed)));
    @(negedge clk);
    check("R4 rvalid one cycle", int'(host_rvalid_o), 0);
    host_read(DEPTH - 1, d, v);
    check({req, " newest entry is last write"}, d, int'(sval(last, seed)));
    host_read(123, d, v);
    check("R5 middle entry", d, int'(sval(last - (DEPTH - 1) + 123, seed)));
    host_read(DEPTH - 2, d, v);
    check("R5 post-freeze samples not stored", d, int'(sval(last - 1, seed)));
    check("R5 still frozen", int'(frozen_o), 1);
  endtask

  task automatic t_source();
    int d, v, bad;
    mode_src_i = 1'b1;
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      host_addr_i  = AW'(a);
      host_wdata_i = pval(a);
      host_wr_i    = 1'b1;
    end
    @(negedge clk);
    host_wr_i = 1'b0;
    host_read(0, d, v);
    check("R8 physical readback 0", d, int'(pval(0)));
    host_read(317, d, v);
    check("R8 physical readback 317", d, int'(pval(317)));
    mode_src_i = 1'b0;
    @(negedge clk);
    mode_src_i = 1'b1;
    bad = 0;
    for (int k = 0; k < 2 * DEPTH + 10; k++) begin
      @(negedge clk);
      if (proc_o != pval(k % DEPTH)) begin
        if (bad == 0) check("R7 replay sequence", int'(proc_o), int'(pval(k % DEPTH)));
        bad++;
      end
    end
    if (bad == 0) check("R7 replay sequence", 0, 0);
    mode_src_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_stop_in_source();
    post_len_i = CNT_W'(0);
    start_i    = 1'b1;
    @(negedge clk);
    start_i    = 1'b0;
    mode_src_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 stop ignored in source", int'(frozen_o), 0);
    mode_src_i = 1'b0;
    live_i     = 10'h2A5;
    @(negedge clk);
    check("R9 recording resumed, not frozen", int'(frozen_o), 0);
    check("R9 passthrough resumed", int'(proc_o), 10'h2A5);
  endtask

  initial begin
    live_i       = '0;
    mode_src_i   = 1'b0;
    start_i      = 1'b0;
    stop_i       = 1'b0;
    post_len_i   = '0;
    host_addr_i  = '0;
    host_rd_i    = 1'b0;
    host_wr_i    = 1'b0;
    host_wdata_i = '0;
    t_reset();
    t_passthrough();
    t_capture(550, 100, 3, "R3");
    t_capture(600, 0, 41, "R10");
    t_source();
    t_stop_in_source();
    finish_run();
  end
endmodule